// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This block performs the clamping arithmetic used by a 32-bit processor's signal-processing instructions. Each cycle it takes two 32-bit operands, a 4-bit operation code and a 5-bit saturate position. It returns a 32-bit result combinationally, in the same cycle. The operations are:

- signed and unsigned add and subtract that clamp instead of wrapping;
- a doubling clamp;
- a plain modular add that only reports signed overflow;
- clamping of a signed value to a chosen bit position, in signed or unsigned form, over the full word or over each 16-bit half separately.

A registered sticky flag records whether any flag-raising operation has clamped since the flag was last cleared. The flag has its own clear input. The block sits beside the execution datapath. Instruction decode and register-file access belong to the surrounding pipeline.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed clamping add): a signed overflow occurs when both operands share a sign and the sum's sign differs from opnd_a. On overflow the result is 0x7FFFFFFF if opnd_a is non-negative and 0x80000000 otherwise, and the flag is raised. Without overflow the result is the sum.
- R2: Opcode 1 (signed clamping subtract): a signed overflow occurs when the operand signs differ and the difference's sign differs from opnd_a. The clamp values and the flag behave as in R1.
- R3: Opcode 3 (flagging add): the result is always the modular 32-bit sum, and the flag is raised on a signed overflow as defined in R1.
- R4: Opcode 2 (doubling clamp of opnd_a): the result is 0x7FFFFFFF when opnd_a ≥ 0x40000000 as a signed value, and 0x80000000 when opnd_a ≤ 0xC0000000 as a signed value. Both cases raise the flag. Otherwise the result is opnd_a shifted left by one.
- R5: Opcodes 4 and 5 (unsigned add and subtract): on a carry out, the add returns 0xFFFFFFFF. On a borrow, the subtract returns 0. Neither raises the flag.
- R6: Opcode 6 (signed clamp) clamps signed opnd_a, with n = sat_pos (0..31), to the range −2^n through 2^n − 1. It raises the flag when it clamps.
- R7: Opcode 7 (unsigned clamp) maps a negative opnd_a to 0 and a value above 2^n − 1 to 2^n − 1. It raises the flag when it clamps.
- R8: Opcodes 8 (signed) and 9 (unsigned) treat bits 15:0 and bits 31:16 as separate sign-extended 16-bit values. Each half is clamped as in R6 or R7 with the same n, and the low 16 bits of each half's result go back into that half. The flag is raised if either half clamps.
- R9: The sticky flag is 0 after reset. A clamp in one cycle makes the flag 1 from the next cycle onward. sat_clr without a clamp makes it 0 in the next cycle. Otherwise the flag holds its value.
- R10: When sat_clr and a clamp occur in the same cycle, the flag is 1 in the next cycle.
- R11: Opcodes 10 to 15 produce a result of 0 and raise nothing, so the flag is unchanged unless sat_clr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand, or the value to be clamped |
| opnd_b | input | 32 | Second operand |
| sat_pos | input | 5 | Clamp bit position n |
| sat_clr | input | 1 | Clears the sticky flag |
| res_out | output | 32 | Combinational result |
| sat_flag | output | 1 | Registered sticky clamp flag |

## Verification
The clocked properties sample the operands and opcode at the rising edge. They take for granted that these inputs are steady at that edge and belong to one operation for the whole cycle. The stimulus therefore changes every input shortly after a rising edge and holds it for a full cycle. Idle cycles carry an undefined opcode with sat_clr low, so no unintended clamp or clear reaches the flag. Operands include the values on either side of each threshold (0x3FFFFFFF/0x40000000, 0xC0000000/0xC0000001, ±2^n at every position, 16-bit extremes) so that every comparator edge is crossed in both directions.

// File: rtl/sat_alu_pkg.sv
// Shared encodings for the saturating arithmetic unit.
// Assumes: opcodes not listed here are treated as undefined (result 0).
package sat_alu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_QADD   = 4'd0,
        OP_QSUB   = 4'd1,
        OP_QDBL   = 4'd2,
        OP_ADDF   = 4'd3,
        OP_UQADD  = 4'd4,
        OP_UQSUB  = 4'd5,
        OP_SSAT   = 4'd6,
        OP_USAT   = 4'd7,
        OP_SSAT16 = 4'd8,
        OP_USAT16 = 4'd9
    } sat_op_e;

    localparam logic [OPW-1:0] OP_LAST = 4'd9;

endpackage

// File: rtl/sat_addsub.sv
// Add/subtract datapath: produces every add-family result in parallel.
// Signed overflow is judged from operand and result sign bits; unsigned
// carry/borrow from the extra top bit. Assumes DW >= 3.
module sat_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] qadd_res,
    output logic [DW-1:0] qsub_res,
    output logic [DW-1:0] qdbl_res,
    output logic [DW-1:0] wrap_res,
    output logic [DW-1:0] uqadd_res,
    output logic [DW-1:0] uqsub_res,
    output logic          add_ovf,
    output logic          sub_ovf,
    output logic          dbl_clip
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] QUART_P = {2'b01, {(DW-2){1'b0}}};
    localparam logic [DW-1:0] QUART_N = {2'b11, {(DW-2){1'b0}}};

    logic [DW:0]   usum;
    logic [DW:0]   udif;
    logic [DW-1:0] sum;
    logic [DW-1:0] dif;
    logic [DW-1:0] clip_val;
    logic          dbl_hi;
    logic          dbl_lo;

    // Extended-width sum and difference expose carry and borrow.
    always_comb begin
        usum = {1'b0, a_in} + {1'b0, b_in};
        udif = {1'b0, a_in} - {1'b0, b_in};
        sum  = usum[DW-1:0];
        dif  = udif[DW-1:0];
    end

    // Signed overflow from sign bits; clamp direction follows operand a.
    always_comb begin
        add_ovf  = (a_in[DW-1] == b_in[DW-1]) && (sum[DW-1] != a_in[DW-1]);
        sub_ovf  = (a_in[DW-1] != b_in[DW-1]) && (dif[DW-1] != a_in[DW-1]);
        clip_val = a_in[DW-1] ? NEG_MIN : POS_MAX;
        qadd_res = add_ovf ? clip_val : sum;
        qsub_res = sub_ovf ? clip_val : dif;
        wrap_res = sum;
    end

    // Doubling clamp against the quarter-range thresholds.
    always_comb begin
        dbl_hi   = $signed(a_in) >= $signed(QUART_P);
        dbl_lo   = $signed(a_in) <= $signed(QUART_N);
        dbl_clip = dbl_hi || dbl_lo;
        if (dbl_hi)      qdbl_res = POS_MAX;
        else if (dbl_lo) qdbl_res = NEG_MIN;
        else             qdbl_res = {a_in[DW-2:0], 1'b0};
    end

    // Unsigned clamping: all ones on carry, zero on borrow.
    always_comb begin
        uqadd_res = usum[DW] ? {DW{1'b1}} : sum;
        uqsub_res = udif[DW] ? '0 : dif;
    end

endmodule

// File: rtl/sat_clamp.sv
// Clamps a signed W-bit value to a bit position n taken from pos_in.
// Signed mode range: -2^n .. 2^n-1; unsigned mode range: 0 .. 2^n-1.
// A position at or beyond W-1 leaves the upper limit at the W-bit signed
// maximum, so such inputs are never clamped from above.
module sat_clamp #(
    parameter int W  = 32,
    parameter int PW = 5
) (
    input  logic [W-1:0]  val_in,
    input  logic [PW-1:0] pos_in,
    input  logic          signed_mode,
    output logic [W-1:0]  clamp_res,
    output logic          clipped
);
    localparam logic [W-1:0] TOP_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] lim_hi;
    logic [W-1:0] lim_lo;
    logic         over;
    logic         under;

    // Limits from the position: 2^n-1 above, its complement or 0 below.
    always_comb begin
        if (int'(pos_in) >= W - 1) lim_hi = TOP_POS;
        else                       lim_hi = (ONE << pos_in) - ONE;
        lim_lo = signed_mode ? ~lim_hi : '0;
    end

    // Compare as signed values and select the clamped output.
    always_comb begin
        over    = $signed(val_in) > $signed(lim_hi);
        under   = $signed(val_in) < $signed(lim_lo);
        clipped = over || under;
        if (over)       clamp_res = lim_hi;
        else if (under) clamp_res = lim_lo;
        else            clamp_res = val_in;
    end

endmodule

// File: rtl/sat_sticky.sv
// Sticky clamp flag: set by any clamp, cleared only by clr_in; a clamp
// wins over a clear in the same cycle. Synchronous active-low reset.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic sat_in,
    input  logic clr_in,
    output logic flag_q
);
    // Flag register: reset to 0, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (sat_in) flag_q <= 1'b1;
        else if (clr_in) flag_q <= 1'b0;
    end

    // R9: a clamp shows up as a set flag one cycle later
    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_in |=> flag_q);
    // R10: a simultaneous clear does not beat a clamp
    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_in && clr_in) |=> flag_q);
    // R9: a clear without a clamp empties the flag
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && !sat_in) |=> !flag_q);
    // R9: without a clear, a set flag stays set
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_in) |=> flag_q);

endmodule

// File: rtl/sat_alu.sv
// Saturating arithmetic unit top. Result is combinational from the
// inputs; the sticky flag registers the selected clamp indication.
// Assumes inputs are steady around each rising clock edge.
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DW  = 32,
    parameter int PW  = 5,
    parameter int NHF = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  opnd_a,
    input  logic [DW-1:0]  opnd_b,
    input  logic [PW-1:0]  sat_pos,
    input  logic           sat_clr,
    output logic [DW-1:0]  res_out,
    output logic           sat_flag
);
    localparam int HW = DW / NHF;

    sat_op_e       op;
    logic [DW-1:0] qadd_res, qsub_res, qdbl_res, wrap_res;
    logic [DW-1:0] uqadd_res, uqsub_res, word_res;
    logic          add_ovf, sub_ovf, dbl_clip, word_clip;
    logic [DW-1:0] half_res;
    logic [NHF-1:0] half_clip;
    logic          sat_now;

    assign op = sat_op_e'(op_code);

    sat_addsub #(.DW(DW)) u_addsub (
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .qadd_res  (qadd_res),
        .qsub_res  (qsub_res),
        .qdbl_res  (qdbl_res),
        .wrap_res  (wrap_res),
        .uqadd_res (uqadd_res),
        .uqsub_res (uqsub_res),
        .add_ovf   (add_ovf),
        .sub_ovf   (sub_ovf),
        .dbl_clip  (dbl_clip)
    );

    sat_clamp #(.W(DW), .PW(PW)) u_word (
        .val_in      (opnd_a),
        .pos_in      (sat_pos),
        .signed_mode (op == OP_SSAT),
        .clamp_res   (word_res),
        .clipped     (word_clip)
    );

    // One clamp per half, each fed its own sign-extended slice.
    for (genvar g = 0; g < NHF; g++) begin : g_half
        sat_clamp #(.W(HW), .PW(PW)) u_half (
            .val_in      (opnd_a[g*HW +: HW]),
            .pos_in      (sat_pos),
            .signed_mode (op == OP_SSAT16),
            .clamp_res   (half_res[g*HW +: HW]),
            .clipped     (half_clip[g])
        );
    end

    // Operation select for result and clamp indication.
    always_comb begin
        res_out = '0;
        sat_now = 1'b0;
        case (op)
            OP_QADD:   begin res_out = qadd_res;  sat_now = add_ovf;    end
            OP_QSUB:   begin res_out = qsub_res;  sat_now = sub_ovf;    end
            OP_QDBL:   begin res_out = qdbl_res;  sat_now = dbl_clip;   end
            OP_ADDF:   begin res_out = wrap_res;  sat_now = add_ovf;    end
            OP_UQADD:  res_out = uqadd_res;
            OP_UQSUB:  res_out = uqsub_res;
            OP_SSAT,
            OP_USAT:   begin res_out = word_res;  sat_now = word_clip;  end
            OP_SSAT16,
            OP_USAT16: begin res_out = half_res;  sat_now = |half_clip; end
            default:   begin res_out = '0;        sat_now = 1'b0;       end
        endcase
    end

    sat_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .sat_in (sat_now),
        .clr_in (sat_clr),
        .flag_q (sat_flag)
    );

    // R5: an unsigned clamping add never yields less than opnd_a
    p_uadd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_UQADD) |-> (res_out >= opnd_a));
    // R5: an unsigned clamping subtract never yields more than opnd_a
    p_usub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_UQSUB) |-> (res_out <= opnd_a));
    // R7: an unsigned clamp result is never negative
    p_usat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_USAT) |-> !res_out[DW-1]);
    // R11: undefined opcodes give zero
    p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > OP_LAST) |-> (res_out == '0));

endmodule

// File: tb/sim_sat_alu.sv
// Scoreboard bench: the driver applies one operation per cycle and
// queues the expected result and flag; the monitor compares at negedge.
module sim_sat_alu;
    import sat_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd15;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_pos = '0;
    logic        sat_clr = 1'b0;
    logic [31:0] res_out;
    logic        sat_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic model_flag = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        flag;
        string       rtag;
        string       ftag;
        logic [3:0]  op;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    sat_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .sat_pos(sat_pos), .sat_clr(sat_clr),
        .res_out(res_out), .sat_flag(sat_flag)
    );

    function automatic void clip64(input longint v, input longint lo,
                                   input longint hi, output longint o,
                                   output logic c);
        c = 1'b0;
        o = v;
        if (v > hi) begin o = hi; c = 1'b1; end
        else if (v < lo) begin o = lo; c = 1'b1; end
    endfunction

    // Reference model in 64-bit signed arithmetic.
    function automatic void ref_model(input logic [3:0] op,
                                      input logic [31:0] a, input logic [31:0] b,
                                      input logic [4:0] n,
                                      output logic [31:0] r, output logic s);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint mx = 64'sd2147483647;
        longint mn = -64'sd2147483648;
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint lim = (64'sd1 <<< n);
        longint o, o2, h0, h1;
        logic c, c2;
        r = '0;
        s = 1'b0;
        case (op)
            4'd0: begin clip64(sa + sb, mn, mx, o, c); r = o[31:0]; s = c; end
            4'd1: begin clip64(sa - sb, mn, mx, o, c); r = o[31:0]; s = c; end
            4'd2: begin
                if (sa >= 64'sd1073741824)       begin r = 32'h7FFFFFFF; s = 1; end
                else if (sa <= -64'sd1073741824) begin r = 32'h80000000; s = 1; end
                else begin o = sa * 2; r = o[31:0]; end
            end
            4'd3: begin clip64(sa + sb, mn, mx, o, c); r = a + b; s = c; end
            4'd4: begin o = ua + ub; r = (o > 64'sd4294967295) ? 32'hFFFFFFFF : o[31:0]; end
            4'd5: begin r = (ua < ub) ? 32'd0 : a - b; end
            4'd6: begin clip64(sa, -lim, lim - 1, o, c); r = o[31:0]; s = c; end
            4'd7: begin clip64(sa, 0, lim - 1, o, c); r = o[31:0]; s = c; end
            4'd8, 4'd9: begin
                h0 = longint'($signed(a[15:0]));
                h1 = longint'($signed(a[31:16]));
                clip64(h0, (op == 4'd8) ? -lim : 64'sd0, lim - 1, o, c);
                clip64(h1, (op == 4'd8) ? -lim : 64'sd0, lim - 1, o2, c2);
                r = {o2[15:0], o[15:0]};
                s = c | c2;
            end
            default: begin r = '0; s = 1'b0; end
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3: return "R3";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Driver: apply one operation and queue what must be seen this cycle.
    task automatic do_op(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] n,
                         input logic clr, input string ftag);
        item_t it;
        logic [31:0] r;
        logic s;
        @(posedge clk);
        #1;
        op_code = op; opnd_a = a; opnd_b = b; sat_pos = n; sat_clr = clr;
        ref_model(op, a, b, n, r, s);
        it.res = r;
        it.flag = model_flag;
        it.rtag = tag_of(op);
        it.ftag = ftag;
        it.op = op;
        sb_q.push_back(it);
        model_flag = s | (model_flag & ~clr);
    endtask

    // Monitor: pop and compare away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (res_out !== it.res) begin
                    bad++;
                    $display("FAIL %s op=%0d res=%h exp=%h", it.rtag, it.op, res_out, it.res);
                end
                total++;
                if (sat_flag !== it.flag) begin
                    bad++;
                    $display("FAIL %s op=%0d flag=%b exp=%b", it.ftag, it.op, sat_flag, it.flag);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [31:0] edges [12] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                                32'hFFFFFFFF, 32'h40000000, 32'h3FFFFFFF,
                                32'hC0000000, 32'hC0000001, 32'h00007FFF,
                                32'h00008000, 32'hFFFF8000};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (sat_flag !== 1'b0) begin
            bad++;
            $display("FAIL R9 reset flag=%b exp=0", sat_flag);
        end

        // R9/R10: directed sticky sequences
        do_op(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0, "R9");  // clamp
        do_op(4'd15, 0, 0, 5'd0, 1'b0, "R9");                 // flag now 1
        do_op(4'd15, 0, 0, 5'd0, 1'b1, "R9");                 // clear
        do_op(4'd15, 0, 0, 5'd0, 1'b0, "R9");                 // flag now 0
        do_op(4'd1, 32'h80000000, 32'h1, 5'd0, 1'b1, "R10");  // clamp + clear
        do_op(4'd15, 0, 0, 5'd0, 1'b0, "R10");                // flag stays 1
        do_op(4'd15, 0, 0, 5'd0, 1'b1, "R9");
        do_op(4'd4, 32'hFFFFFFFF, 32'h2, 5'd0, 1'b0, "R5");   // unsigned: no flag
        do_op(4'd5, 32'h1, 32'h2, 5'd0, 1'b0, "R5");
        do_op(4'd12, 32'h7FFFFFFF, 32'h1, 5'd3, 1'b0, "R11"); // undefined: no flag
        do_op(4'd15, 0, 0, 5'd0, 1'b0, "R11");

        // Boundary operand pairs across every defined opcode
        for (int op = 0; op < 10; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    do_op(op[3:0], edges[i], edges[j], 5'(j * 3 % 32),
                          (j == 11), "R9");

        // Thresholds at every clamp position, word and halfword forms
        for (int n = 0; n < 32; n++)
            for (int op = 6; op < 10; op++) begin
                logic [31:0] p;
                p = 32'd1 << n;
                do_op(op[3:0], p, 0, n[4:0], 1'b0, "R9");
                do_op(op[3:0], p - 1, 0, n[4:0], 1'b0, "R9");
                do_op(op[3:0], -p, 0, n[4:0], 1'b1, "R9");
                do_op(op[3:0], -p - 1, 0, n[4:0], 1'b0, "R9");
                do_op(op[3:0], {p[15:0] - 16'd1, -p[15:0]}, 0, n[4:0], 1'b0, "R9");
            end

        // Random operands, including undefined opcodes and clears
        for (int k = 0; k < 3000; k++)
            do_op(4'($urandom_range(0, 15)), $urandom, $urandom,
                  5'($urandom_range(0, 31)), ($urandom_range(0, 7) == 0), "R9");

        do_op(4'd15, 0, 0, 5'd0, 1'b0, "R9");
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule